// File: doc/BRIEF.md
# Background Memory Scrub Request Generator

This block walks the installed memory one cache line at a time and asks the memory request queue for a scrub on each line at a fixed pace. A scrub is an atomic read-then-write-back of the line. It is done whether or not the line holds an error, so stored ECC is refreshed with corrected data. The request carries an operation code that marks it as such an atomic operation. It is pushed straight into the memory queue, without bus snooping and without comparing its address against other queued entries.

The pacing timer fires once per interval (65536 clocks by default). If the queue back-pressures the request, the request is held until it is accepted, and the next interval is timed from the acceptance. The line pointer advances after each accepted request and returns to zero past the last installed line, and a one-cycle wrap pulse marks the end of each sweep. The installed size is given in lines, so the time for a full sweep grows in proportion to the memory size. A configuration enable stops the engine without losing its place in the sweep.

Top module: `scrub_walker`

## Requirements
- R1: After a synchronous reset, req_valid, req_op and sweep_wrap are 0, and the first request issued targets line 0.
- R2: With cfg_en high and ready high, the first req_valid appears after exactly INTERVAL enabled clock edges counted from reset or from enabling. After that, each acceptance is followed by the next acceptance exactly INTERVAL cycles later. No request rises while cfg_en is low.
- R3: While req_valid is high and req_ready is low (and cfg_en stays high), req_valid stays high and req_addr stays unchanged. The next interval does not start until the request is accepted.
- R4: req_op is 2'b11 (atomic scrub read-modify-write, no snoop, no conflict check) whenever req_valid is high, and 2'b00 otherwise.
- R5: After line A is accepted, the next request targets A+1. If A+1 is equal to or greater than mem_lines, the next request targets 0.
- R6: sweep_wrap is high for exactly the one cycle that follows the acceptance of a request whose address plus one reaches or passes mem_lines, and it is low at all other times.
- R7: When cfg_en goes low, req_valid drops at the next edge (any unaccepted request is withdrawn) and the interval count restarts from zero.
- R8: Disabling keeps the line pointer. After re-enabling, the next request targets the line that would have come next.
- R9: When mem_lines is 0, no request is issued. If the pointer lies at or beyond mem_lines when a request is issued, that request targets line 0.
- R10: With req_ready held high, the spacing between sweep_wrap pulses equals mem_lines × INTERVAL cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Scrub enable |
| mem_lines | input | ADDR_W+1 | Installed memory size in lines |
| req_ready | input | 1 | Memory queue can accept the request |
| req_valid | output | 1 | Scrub request pending |
| req_addr | output | ADDR_W | Line address of the request |
| req_op | output | 2 | Operation code: 2'b11 scrub RMW, 2'b00 none |
| sweep_wrap | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
With ready held high, the design is run at two memory sizes. The wrap spacing shows whether the sweep time scales with size, and it separates an exact interval from one that is off by a cycle. Long stretches of random ready, combined with random enable toggles and size changes, are compared cycle by cycle against a bench model. This separates a held request from one that is dropped or advanced during a stall. Directed cases cover a zero size and a pointer left beyond a shrunken size, which test the guard on an empty or out-of-range sweep. A disable and re-enable taken in the middle of a stall tests the withdrawal of the request, the restart of the timer and the kept pointer.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [1:0] {
    SOP_NONE = 2'b00,
    SOP_RMW  = 2'b11
  } scrub_op_e;
endpackage

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int INTERVAL = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hold,
  input  logic restart,
  input  logic armed,
  output logic fire
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign fire = en && !hold && !restart && armed && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= CW'(1);
    end else if (!hold) begin
      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end

  assert_count_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !hold && !restart) |=> (cnt == $past(cnt) + CW'(1) || cnt == '0));
  assert_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);
endmodule

// File: rtl/scrub_req_stage.sv
module scrub_req_stage
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fire,
  input  logic [ADDR_W-1:0] line_sel,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        op,
  output logic              accept
);
  assign accept = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      op    <= SOP_NONE;
    end else if (accept || !en) begin
      valid <= 1'b0;
      op    <= SOP_NONE;
    end else if (fire) begin
      valid <= 1'b1;
      addr  <= line_sel;
      op    <= SOP_RMW;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && en) |=> (valid && $stable(addr)));
  assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid);
endmodule

// File: rtl/scrub_addr_walk.sv
module scrub_addr_walk #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W:0]   lines,
  input  logic              accept,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] line_sel,
  output logic              wrap
);
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W:0]   nxt;
  logic              at_end;

  assign line_sel = ({1'b0, cur} < lines) ? cur : '0;
  assign nxt      = {1'b0, acc_addr} + (ADDR_W+1)'(1);
  assign at_end   = (nxt >= lines);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= accept && at_end;
      if (accept) cur <= at_end ? '0 : nxt[ADDR_W-1:0];
    end
  end

  assert_wrap_src_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |-> $past(accept));
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |-> cur == '0);
endmodule

// File: rtl/scrub_walker.sv
module scrub_walker
  import scrub_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INTERVAL = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [ADDR_W:0]   mem_lines,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_op,
  output logic              sweep_wrap
);
  logic              fire;
  logic              accept;
  logic [ADDR_W-1:0] line_sel;
  logic              armed;

  assign armed = (mem_lines != '0);

  scrub_pacer #(.INTERVAL(INTERVAL)) pacer_i (
    .clk(clk), .rst(rst), .en(cfg_en), .hold(req_valid),
    .restart(accept), .armed(armed), .fire(fire)
  );

  scrub_req_stage #(.ADDR_W(ADDR_W)) stage_i (
    .clk(clk), .rst(rst), .en(cfg_en), .fire(fire), .line_sel(line_sel),
    .ready(req_ready), .valid(req_valid), .addr(req_addr), .op(req_op),
    .accept(accept)
  );

  scrub_addr_walk #(.ADDR_W(ADDR_W)) walk_i (
    .clk(clk), .rst(rst), .lines(mem_lines), .accept(accept),
    .acc_addr(req_addr), .line_sel(line_sel), .wrap(sweep_wrap)
  );

  assert_rise_en_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> $past(cfg_en));
  assert_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_lines == '0 && !req_valid) |=> !req_valid);
  assert_op_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_op == SOP_RMW);
endmodule

// File: tb/scrub_walker_tb_top.sv
module scrub_walker_tb_top;
  localparam int AW  = 6;
  localparam int IV  = 16;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic [AW:0] mem_lines = 7'd8;
  logic req_ready = 1'b1;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0] req_op;
  logic sweep_wrap;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // bench model state
  int m_since = 0, m_addr = 0, m_cur = 0;
  bit m_valid = 0, m_wrap = 0;

  always #2 clk = ~clk;

  scrub_walker #(.ADDR_W(AW), .INTERVAL(IV)) dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .mem_lines(mem_lines),
    .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .sweep_wrap(sweep_wrap)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int next_line(input int a, input int n);
    return (a + 1 >= n) ? 0 : a + 1;
  endfunction

  // model of the requirements, stepped at each edge
  always @(posedge clk) begin
    bit acc;
    int n;
    n = int'(mem_lines);
    if (rst) begin
      m_since = 0; m_addr = 0; m_cur = 0; m_valid = 0; m_wrap = 0;
    end else begin
      acc = m_valid && req_ready;
      m_wrap = acc && (m_addr + 1 >= n);
      if (acc) begin
        m_cur = next_line(m_addr, n); m_valid = 0; m_since = 1;
      end else if (!cfg_en) begin
        m_valid = 0; m_since = 0;
      end else if (!m_valid) begin
        if (m_since == IV - 1) begin
          m_since = 0;
          if (n != 0) begin
            m_valid = 1; m_addr = (m_cur < n) ? m_cur : 0;
          end
        end else m_since++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk(req_valid == m_valid, "R2/R3/R7 valid", req_valid, m_valid);
      if (m_valid) chk(int'(req_addr) == m_addr, "R5 addr", req_addr, m_addr);
      chk(req_op == (m_valid ? 2'b11 : 2'b00), "R4 op", req_op, m_valid ? 3 : 0);
      chk(sweep_wrap == m_wrap, "R6 wrap", sweep_wrap, m_wrap);
    end
    if (cyc > WDOG && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_wrap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sweep_wrap);
  endtask

  initial begin
    int k, a;
    void'($urandom(32'h5C2B));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_valid == 0, "R1 valid", req_valid, 0);
    chk(req_op == 2'b00, "R1 op", req_op, 0);
    chk(sweep_wrap == 0, "R1 wrap", sweep_wrap, 0);
    rst = 0; mem_lines = 7'd5; req_ready = 1;
    @(negedge clk);
    cfg_en = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!req_valid && k < 100);
    chk(k == IV, "R2 first interval", k, IV);
    chk(req_addr == 0, "R1 first addr", req_addr, 0);
    // R10 sweep time scales with size
    wait_wrap(k);
    wait_wrap(k);
    chk(k == 5 * IV, "R10 sweep 5 lines", k, 5 * IV);
    mem_lines = 7'd10;
    wait_wrap(k);
    chk(k == 10 * IV, "R10 sweep 10 lines", k, 10 * IV);

    // R3/R7/R8: stall, disable, re-enable
    req_ready = 0;
    do @(negedge clk); while (!req_valid);
    a = req_addr;
    repeat (5) @(negedge clk);
    chk(req_valid && req_addr == a, "R3 held", req_addr, a);
    cfg_en = 0;
    @(negedge clk);
    chk(req_valid == 0, "R7 withdrawn", req_valid, 0);
    repeat (7) @(negedge clk);
    req_ready = 1; cfg_en = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!req_valid && k < 100);
    chk(k == IV, "R7 restart interval", k, IV);
    chk(req_addr == a, "R8 resumed addr", req_addr, a);

    // R9 zero size
    mem_lines = 0;
    k = 0;
    repeat (5 * IV) begin @(negedge clk); if (req_valid) k++; end
    chk(k <= 1, "R9 no requests", k, 0);
    // R9 pointer beyond shrunk size
    mem_lines = 7'd40;
    do @(negedge clk); while (!(req_valid && req_addr == 6'd12));
    @(negedge clk);
    mem_lines = 7'd3;
    do @(negedge clk); while (!req_valid);
    chk(req_addr == 0, "R9 out of range issues 0", req_addr, 0);

    // random phase, model compared every cycle
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      req_ready = ($urandom % 4) != 0;
      if ($urandom % 500 == 0) cfg_en = ~cfg_en;
      if ($urandom % 700 == 0) mem_lines = 7'(1 + $urandom % 64);
    end
    cfg_en = 1;
    repeat (50) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule